// File: doc/BRIEF.md
# Sleep-Mode Power Control Register

This block holds the sleep configuration of a mixed-signal device and decides, each cycle, which enable reaches the 32 kHz oscillator, the clock output buffer and the PWM. A serial host interface, outside this block, decodes each register access into a one-cycle strobe. The strobe carries the register address, a read/write flag, the least significant bit of the address control byte and one write data byte. On the configuration address, that address LSB is a sleep command. It is not a data bit.

A sleep command sets a read-only shutdown flag. Shutdown is also set by a write to a dedicated sleep address. It is cleared by a write to the normal-mode address, by a day-alarm pulse or by a rising edge on the wake input. A wake event wins over a sleep command that arrives in the same cycle. While shutdown is set, each peripheral enable is taken from its sleep-mode bit, and the normal-mode enable supplied from elsewhere is ignored. The PWM sleep enable only passes when the sleep oscillator enable is also set. This is because in sleep the PWM can only run from the slow oscillator.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: A write strobe to the configuration address with the address LSB at 1 sets shutdown. The change shows from the cycle after the strobe.
- R2: A write to the configuration address with the LSB at 0 leaves shutdown unchanged. Any read, to any address and with either LSB value, also leaves shutdown and the stored enable bits unchanged.
- R3: A write strobe to the sleep address (`SLEEP_ADDR`) sets shutdown on the next cycle, whatever the LSB and the data are.
- R4: Shutdown clears on the cycle after any one of these: a write to the normal-mode address (`NORM_ADDR`), a day-alarm pulse, or a 0-to-1 transition of `wake_in` between two consecutive clock edges.
- R5: While shutdown is set, `osc_en` equals the sleep oscillator bit and `clkout_en` equals the sleep buffer bit, and `osc_en_norm`/`clkout_en_norm` have no effect. While shutdown is clear, the two outputs follow the normal-mode inputs.
- R6: `sleep_out` is high whenever shutdown is set, even when `ext_sleep` is low. Otherwise it equals `ext_sleep`.
- R7: `rd_data` always shows {sleep osc bit, sleep buffer bit, sleep PWM bit, shutdown, 4'b0000}, from bit 7 down to bit 0. After reset it reads 8'hC0.
- R8: While shutdown is set, `pwm_en` is the sleep PWM bit ANDed with the sleep oscillator bit. While shutdown is clear, it follows `pwm_en_norm`.
- R9: When a wake event and a sleep-setting write fall in the same cycle, shutdown is clear afterwards.
- R10: A write to the configuration address loads data bits 7, 6 and 5 into the sleep oscillator, buffer and PWM bits. Data bit 4 has no effect on shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-cycle register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register address (the address byte without its LSB) |
| acc_lsb | input | 1 | LSB of the address control byte (sleep command) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Configuration register readback |
| day_alarm | input | 1 | Day alarm pulse (wake source) |
| wake_in | input | 1 | Wake-up pin level, synchronous (rising edge wakes) |
| ext_sleep | input | 1 | External sleep pin function |
| osc_en_norm | input | 1 | Normal-mode oscillator enable |
| clkout_en_norm | input | 1 | Normal-mode clock buffer enable |
| pwm_en_norm | input | 1 | Normal-mode PWM enable |
| osc_en | output | 1 | Effective oscillator enable |
| clkout_en | output | 1 | Effective clock buffer enable |
| pwm_en | output | 1 | Effective PWM enable |
| sleep_out | output | 1 | Device-level sleep request |

## Verification
Every state bit is visible on `rd_data` in the same cycle. A wrong shutdown flag or a wrong sleep enable bit therefore shows at the port one clock after the access or wake event that caused it. A wrong shutdown flag also shows at once on the enable outputs and on `sleep_out`, as long as the normal-mode inputs differ from the sleep bits. A wake edge detector holding a stale sample makes the flag clear one cycle late or not at all. Back-to-back wake and sleep stimulus exposes this.

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 7'h2A,
  parameter logic [ADDR_W-1:0] SLEEP_ADDR = 7'h2B,
  parameter logic [ADDR_W-1:0] NORM_ADDR  = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_lsb,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              day_alarm,
  input  logic              wake_in,
  input  logic              ext_sleep,
  input  logic              osc_en_norm,
  input  logic              clkout_en_norm,
  input  logic              pwm_en_norm,
  output logic              osc_en,
  output logic              clkout_en,
  output logic              pwm_en,
  output logic              sleep_out
);

  logic s_osc, s_ck, s_pwm, shdn, wake_q;

  wire wr       = acc_valid & acc_write;
  wire cfg_wr   = wr & (acc_addr == CFG_ADDR);
  wire set_req  = (cfg_wr & acc_lsb) | (wr & (acc_addr == SLEEP_ADDR));
  wire wake_evt = (wr & (acc_addr == NORM_ADDR)) | day_alarm | (wake_in & ~wake_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_osc  <= 1'b1;
      s_ck   <= 1'b1;
      s_pwm  <= 1'b0;
      shdn   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_in;
      if (cfg_wr) {s_osc, s_ck, s_pwm} <= wr_data[7:5];
      if (wake_evt)     shdn <= 1'b0;
      else if (set_req) shdn <= 1'b1;
    end
  end

  assign rd_data   = {s_osc, s_ck, s_pwm, shdn, 4'b0000};
  assign osc_en    = shdn ? s_osc : osc_en_norm;
  assign clkout_en = shdn ? s_ck : clkout_en_norm;
  assign pwm_en    = shdn ? (s_pwm & s_osc) : pwm_en_norm;
  assign sleep_out = shdn | ext_sleep;

  p_cfg_sleep_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && acc_lsb && !wake_evt) |=> rd_data[4]);

  p_sleep_addr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_addr == SLEEP_ADDR && !wake_evt) |=> rd_data[4]);

  p_quiet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !wake_evt) |=> $stable(shdn));

  p_alarm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_alarm |=> !rd_data[4]);

  p_wake_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && wake_evt) |=> !shdn);

  p_pwm_needs_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && pwm_en) |-> osc_en);

  p_sleep_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> sleep_out);

endmodule

// File: tb/sleep_pwr_ctrl_tb.sv
module sleep_pwr_ctrl_tb;
  localparam logic [6:0] CFG = 7'h2A, SLP = 7'h2B, NRM = 7'h2C;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_lsb = 0;
  logic [6:0] acc_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic day_alarm = 0, wake_in = 0, ext_sleep = 0;
  logic osc_en_norm = 0, clkout_en_norm = 0, pwm_en_norm = 0;
  logic osc_en, clkout_en, pwm_en, sleep_out;

  int checks = 0, fails = 0;
  logic m_osc = 1, m_ck = 1, m_pwm = 0, m_sh = 0, m_wq = 0;

  always #4 clk = ~clk;

  sleep_pwr_ctrl u_dut (.clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_lsb,
    .wr_data, .rd_data, .day_alarm, .wake_in, .ext_sleep, .osc_en_norm,
    .clkout_en_norm, .pwm_en_norm, .osc_en, .clkout_en, .pwm_en, .sleep_out);

  function automatic logic [7:0] exp_rd();
    return {m_osc, m_ck, m_pwm, m_sh, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_lsb = 0; acc_addr = 0; wr_data = 0; day_alarm = 0;
  endtask

  task automatic cyc(input string tag);
    logic wr, setq, clr;
    #1;
    chk({tag, " rd_data"}, rd_data, exp_rd());
    chk("R5 osc_en", {7'b0, osc_en}, {7'b0, m_sh ? m_osc : osc_en_norm});
    chk("R5 clkout_en", {7'b0, clkout_en}, {7'b0, m_sh ? m_ck : clkout_en_norm});
    chk("R8 pwm_en", {7'b0, pwm_en}, {7'b0, m_sh ? (m_pwm & m_osc) : pwm_en_norm});
    chk("R6 sleep_out", {7'b0, sleep_out}, {7'b0, m_sh | ext_sleep});
    @(posedge clk);
    wr   = acc_valid & acc_write;
    setq = wr & ((acc_addr == CFG & acc_lsb) | acc_addr == SLP);
    clr  = (wr & acc_addr == NRM) | day_alarm | (wake_in & ~m_wq);
    if (wr && acc_addr == CFG) {m_osc, m_ck, m_pwm} = wr_data[7:5];
    if (clr) m_sh = 0; else if (setq) m_sh = 1;
    m_wq = wake_in;
    @(negedge clk);
    idle();
  endtask

  task automatic acc(input logic w, input logic [6:0] a, input logic l, input logic [7:0] d);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_lsb = l; wr_data = d;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R7 reset value", rd_data, 8'hC0);
    osc_en_norm = 0; clkout_en_norm = 0; pwm_en_norm = 1;
    acc(1, CFG, 0, 8'hF0); cyc("R10 cfg write bit4");
    chk("R10 no shdn from data", rd_data, 8'hE0);
    acc(0, CFG, 1, 8'h00); cyc("R2 read lsb1");
    chk("R2 read no effect", rd_data, 8'hE0);
    acc(1, CFG, 1, 8'h60); cyc("R1 sleep write");
    chk("R1 shdn set", rd_data, 8'h70);
    chk("R8 pwm gated off", {7'b0, pwm_en}, 8'h00);
    cyc("R5 hold");
    acc(1, NRM, 0, 8'h00); cyc("R4 norm write");
    chk("R4 norm clears", rd_data[4], 1'b0);
    acc(1, SLP, 0, 8'h00); cyc("R3 sleep addr");
    chk("R3 set", rd_data[4], 1'b1);
    day_alarm = 1; cyc("R4 alarm");
    chk("R4 alarm clears", rd_data[4], 1'b0);
    acc(1, SLP, 1, 8'h00); cyc("R3 again");
    wake_in = 1; cyc("R4 wake edge");
    chk("R4 wake clears", rd_data[4], 1'b0);
    acc(1, CFG, 1, 8'hC0); cyc("R2 level held no edge");
    chk("R4 level not edge", rd_data[4], 1'b1);
    wake_in = 0; cyc("R4 wake low");
    wake_in = 1; acc(1, SLP, 0, 8'h00); cyc("R9 wake vs sleep");
    chk("R9 wake wins", rd_data[4], 1'b0);
    wake_in = 0;
    acc(1, CFG, 1, 8'hC0); ext_sleep = 0; cyc("R1 set");
    chk("R6 sleep_out in shdn", {7'b0, sleep_out}, 8'h01);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      osc_en_norm = 1'($urandom); clkout_en_norm = 1'($urandom);
      pwm_en_norm = 1'($urandom); ext_sleep = 1'($urandom);
      if ($urandom_range(0, 7) == 0) wake_in = ~wake_in;
      if ($urandom_range(0, 19) == 0) day_alarm = 1;
      if (r < 6) begin
        logic [6:0] a;
        case ($urandom_range(0, 3))
          0: a = CFG; 1: a = SLP; 2: a = NRM; default: a = 7'($urandom);
        endcase
        acc(1'($urandom), a, 1'($urandom), 8'($urandom));
      end
      cyc("R2 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule